// File: doc/BRIEF.md
# I/O Compensation Code Selector

This block decides, for each of two I/O supply domains, which 8-bit drive-strength code reaches the I/O buffers. Each code is a 4-bit PMOS field over a 4-bit NMOS field. A code comes from one of three places:
- a fixed default code, used while the domain's tracking is off;
- the value last sampled from an external process/voltage/temperature tracking cell;
- an override code written by software.

Each domain has an enable bit, a select bit and a ready flag. The ready flag rises only after the domain has been enabled with the reference oscillator running for a programmable number of consecutive cycles, which models the cell's settling time. The tracked value is sampled only while ready is high, so an unsettled value is never captured.

Software reaches the block over a simple word-addressed bus: address, write enable, write data and a combinational read data port. There are three registers:
- a control/status register;
- a read-only captured-value register;
- the override-code register.

The usual flow is: enable a domain, wait for ready, copy the captured value into the override register, set the select bit, then disable tracking to save power.

Top module: `iocomp_sel`

## Requirements
- R1: After reset, address 0 reads 0x0000000A, address 1 reads 0x00000000 and address 2 reads 0x00007878, and both domain codes equal 0x78.
- R2: Word address 0 is control/status, with enable 1 at bit 0, select 1 at bit 1, enable 2 at bit 2, select 2 at bit 3, ready 1 at bit 8 and ready 2 at bit 9. Address 1 is the captured value and address 2 is the override code. Both use bits [3:0] NMOS 1, [7:4] PMOS 1, [11:8] NMOS 2 and [15:12] PMOS 2. Address 3 and all undefined bits read zero, and writes to undefined bits have no effect.
- R3: A domain's ready flag reads 1 after SETTLE_CYC consecutive clock edges at which both its enable bit and `oscOn` are high.
- R4: A ready flag clears on the first clock edge at which its enable bit or `oscOn` is low, and it never asserts while `oscOn` is low.
- R5: With the select bit clear and the enable bit clear, the domain code is the fixed default 0x78.
- R6: With the select bit clear and the enable bit set, the domain code is that domain's captured value.
- R7: With the select bit set, the domain code is that domain's override code, whether the domain is enabled or not.
- R8: At each clock edge where the domain's ready flag is 1, the captured value takes the domain's cell input. Otherwise it holds its last value.
- R9: Writes to address 1 and to the ready bit positions of address 0 have no effect.
- R10: The two domains are independent: the bits, counters and captured value of one domain never change the other domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscOn | input | 1 | Reference oscillator running |
| busAddr | input | 2 | Register word address |
| busWe | input | 1 | Write strobe, sampled on the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| cellCode | input | 2x8 | Tracked {PMOS,NMOS} value per domain from the cell |
| ioCode | output | 2x8 | {PMOS,NMOS} code driven to each domain's I/O buffers |

## Verification
A settle counter that is off by one moves the ready bit at address 0 one cycle early or late. That is seen at the first negative edge after the edge in question. A capture that is not gated by ready shows up at once on `ioCode` when select is clear, and on the next read of address 1. Because the reference model is compared on every cycle, a wrong source choice or a write that leaks into a read-only field is reported within one clock of the stimulus. A swapped field position is reported the first time the affected word is read back.

// File: rtl/iocomp_pkg.sv
package iocomp_pkg;
  localparam int NCH    = 2;
  localparam int CODE_W = 8;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_VAL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CODE = 2'd2;

  localparam logic [CODE_W-1:0] SW_CODE_RST = 8'h78;

  typedef struct packed {
    logic [NCH-1:0]             en;
    logic [NCH-1:0]             sel;
    logic [NCH-1:0][CODE_W-1:0] swCode;
  } ctlStrobe_t;
endpackage

// File: rtl/iocomp_ctrl.sv
module iocomp_ctrl
  import iocomp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWe,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [NCH*CODE_W-1:0]   busWdataLo,
  output ctlStrobe_t              strobe
);
  logic [NCH-1:0]             enQ;
  logic [NCH-1:0]             selQ;
  logic [NCH-1:0][CODE_W-1:0] codeQ;

  logic wrCtl, wrCode;
  assign wrCtl  = busWe && (busAddr == ADDR_CTL);
  assign wrCode = busWe && (busAddr == ADDR_CODE);

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[i]   <= 1'b0;
        selQ[i]  <= 1'b1;
        codeQ[i] <= SW_CODE_RST;
      end else begin
        if (wrCtl) begin
          enQ[i]  <= busWdataLo[2*i];
          selQ[i] <= busWdataLo[2*i+1];
        end
        if (wrCode) codeQ[i] <= busWdataLo[CODE_W*i +: CODE_W];
      end
    end
  end

  assign strobe.en     = enQ;
  assign strobe.sel    = selQ;
  assign strobe.swCode = codeQ;
endmodule

// File: rtl/iocomp_dp.sv
module iocomp_dp
  import iocomp_pkg::*;
#(
  parameter int                SETTLE_CYC = 4,
  parameter logic [CODE_W-1:0] DEF_CODE   = 8'h78
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       oscOn,
  input  ctlStrobe_t                 strobe,
  input  logic [NCH-1:0][CODE_W-1:0] cellCode,
  output logic [NCH-1:0]             rdy,
  output logic [NCH-1:0][CODE_W-1:0] valCap,
  output logic [NCH-1:0][CODE_W-1:0] ioCode
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [CNT_W-1:0]  cnt;
    logic              rdyQ;
    logic [CODE_W-1:0] valQ;
    logic              track;

    assign track = strobe.en[i] && oscOn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        rdyQ <= 1'b0;
        valQ <= '0;
      end else begin
        if (track) begin
          if (!rdyQ) begin
            if (cnt == CNT_LAST) rdyQ <= 1'b1;
            else                 cnt  <= cnt + 1'b1;
          end
        end else begin
          cnt  <= '0;
          rdyQ <= 1'b0;
        end
        if (rdyQ) valQ <= cellCode[i];
      end
    end

    assign rdy[i]    = rdyQ;
    assign valCap[i] = valQ;
    assign ioCode[i] = strobe.sel[i] ? strobe.swCode[i]
                     : (strobe.en[i] ? valQ : DEF_CODE);
  end
endmodule

// File: rtl/iocomp_sel.sv
module iocomp_sel
  import iocomp_pkg::*;
#(
  parameter int                SETTLE_CYC = 4,
  parameter logic [CODE_W-1:0] DEF_CODE   = 8'h78
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       oscOn,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWe,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic [NCH-1:0][CODE_W-1:0] cellCode,
  output logic [NCH-1:0][CODE_W-1:0] ioCode
);
  localparam int LO_W = NCH * CODE_W;

  ctlStrobe_t                 strobe;
  logic [NCH-1:0]             rdy;
  logic [NCH-1:0][CODE_W-1:0] valCap;
  logic                       unusedWdataHi;

  assign unusedWdataHi = ^busWdata[DATA_W-1:LO_W];

  iocomp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .busWdataLo (busWdata[LO_W-1:0]),
    .strobe     (strobe)
  );

  iocomp_dp #(.SETTLE_CYC(SETTLE_CYC), .DEF_CODE(DEF_CODE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .oscOn    (oscOn),
    .strobe   (strobe),
    .cellCode (cellCode),
    .rdy      (rdy),
    .valCap   (valCap),
    .ioCode   (ioCode)
  );

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTL: begin
        for (int i = 0; i < NCH; i++) begin
          busRdata[2*i]   = strobe.en[i];
          busRdata[2*i+1] = strobe.sel[i];
          busRdata[8+i]   = rdy[i];
        end
      end
      ADDR_VAL:  busRdata[LO_W-1:0] = valCap;
      ADDR_CODE: busRdata[LO_W-1:0] = strobe.swCode;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/iocomp_sel_chk.sv
module iocomp_sel_chk
  import iocomp_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEF_CODE = 8'h78
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       oscOn,
  input logic                       busWe,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [NCH-1:0]             en,
  input logic [NCH-1:0]             sel,
  input logic [NCH-1:0]             rdy,
  input logic [NCH-1:0][CODE_W-1:0] swCode,
  input logic [NCH-1:0][CODE_W-1:0] valCap,
  input logic [NCH-1:0][CODE_W-1:0] ioCode
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r4_rdy_drops: assert property (@(posedge clk) disable iff (!rstN)
      !(en[i] && oscOn) |=> !rdy[i]);
    a_r3_rdy_cause: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rdy[i]) |-> $past(en[i] && oscOn));
    a_r8_hold_capture: assert property (@(posedge clk) disable iff (!rstN)
      !rdy[i] |=> $stable(valCap[i]));
    a_r5_default_code: assert property (@(posedge clk) disable iff (!rstN)
      (!en[i] && !sel[i]) |-> ioCode[i] == DEF_CODE);
    a_r7_override_code: assert property (@(posedge clk) disable iff (!rstN)
      sel[i] |-> ioCode[i] == swCode[i]);
  end

  a_r9_value_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_VAL && rdy == '0) |=> $stable(valCap));
endmodule

bind iocomp_sel iocomp_sel_chk #(.DEF_CODE(DEF_CODE)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .oscOn   (oscOn),
  .busWe   (busWe),
  .busAddr (busAddr),
  .en      (strobe.en),
  .sel     (strobe.sel),
  .rdy     (rdy),
  .swCode  (strobe.swCode),
  .valCap  (valCap),
  .ioCode  (ioCode)
);

// File: tb/iocomp_sel_bench.sv
module iocomp_sel_bench;
  localparam int SETTLE = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              oscOn = 1'b0;
  logic [1:0]        busAddr = 2'd0;
  logic              busWe = 1'b0;
  logic [31:0]       busWdata = 32'd0;
  logic [31:0]       busRdata;
  logic [1:0][7:0]   cellCode = '0;
  logic [1:0][7:0]   ioCode;

  iocomp_sel #(.SETTLE_CYC(SETTLE), .DEF_CODE(8'h78)) u_iocomp_sel (
    .clk(clk), .rstN(rstN), .oscOn(oscOn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cellCode(cellCode), .ioCode(ioCode)
  );

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  bit mEn[2] = '{0, 0};
  bit mSel[2] = '{1, 1};
  int mCode[2] = '{8'h78, 8'h78};
  int mCnt[2] = '{0, 0};
  bit mRdy[2] = '{0, 0};
  int mVal[2] = '{0, 0};

  always @(posedge clk) begin
    bit nRdy[2];
    int nCnt[2];
    int nVal[2];
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mEn[i] = 0; mSel[i] = 1; mCode[i] = 8'h78; mCnt[i] = 0; mRdy[i] = 0; mVal[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        nRdy[i] = mRdy[i]; nCnt[i] = mCnt[i]; nVal[i] = mVal[i];
        if (mEn[i] && oscOn) begin
          if (!mRdy[i]) begin
            if (mCnt[i] == SETTLE - 1) nRdy[i] = 1;
            else nCnt[i] = mCnt[i] + 1;
          end
        end else begin
          nCnt[i] = 0; nRdy[i] = 0;
        end
        if (mRdy[i]) nVal[i] = int'(cellCode[i]);
      end
      if (busWe && busAddr == 2'd0) begin
        mEn[0] = busWdata[0]; mSel[0] = busWdata[1];
        mEn[1] = busWdata[2]; mSel[1] = busWdata[3];
      end
      if (busWe && busAddr == 2'd2) begin
        mCode[0] = int'(busWdata[7:0]); mCode[1] = int'(busWdata[15:8]);
      end
      for (int i = 0; i < 2; i++) begin
        mRdy[i] = nRdy[i]; mCnt[i] = nCnt[i]; mVal[i] = nVal[i];
      end
    end
  end

  function automatic logic [31:0] expRead(logic [1:0] a);
    logic [31:0] r = 32'd0;
    case (a)
      2'd0: begin
        r[0] = mEn[0]; r[1] = mSel[0]; r[2] = mEn[1]; r[3] = mSel[1];
        r[8] = mRdy[0]; r[9] = mRdy[1];
      end
      2'd1: r[15:0] = {mVal[1][7:0], mVal[0][7:0]};
      2'd2: r[15:0] = {mCode[1][7:0], mCode[0][7:0]};
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] expIo(int i);
    if (mSel[i]) return mCode[i][7:0];
    if (mEn[i])  return mVal[i][7:0];
    return 8'h78;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("read data", busRdata, expRead(busAddr));
    check("domain 1 code", {24'd0, ioCode[0]}, {24'd0, expIo(0)});
    check("domain 2 code", {24'd0, ioCode[1]}, {24'd0, expIo(1)});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #2;
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(posedge clk); #2;
    busWe = 1'b0;
  endtask

  task automatic setAddr(logic [1:0] a);
    @(posedge clk); #2;
    busAddr = a;
  endtask

  initial begin
    curReq = "R1";
    idle(2);
    rstN = 1'b1;
    for (int a = 0; a < 4; a++) begin setAddr(a[1:0]); idle(1); end

    curReq = "R2";
    wr(2'd2, 32'hFFFF5A3C);
    idle(1);
    setAddr(2'd3); idle(1);
    wr(2'd0, 32'hFFFFFCFA);
    idle(1);

    curReq = "R4";
    oscOn = 1'b0;
    wr(2'd0, 32'h0000000F);
    idle(10);

    curReq = "R7";
    setAddr(2'd2); idle(2);
    setAddr(2'd0);

    curReq = "R3";
    cellCode[0] = 8'hA5; cellCode[1] = 8'h5A;
    oscOn = 1'b1;
    for (int k = 0; k < 3; k++) begin
      idle(1); cellCode[0] = cellCode[0] + 8'h11; cellCode[1] = cellCode[1] ^ 8'hFF;
    end
    cellCode[0] = 8'h96; cellCode[1] = 8'h69;
    idle(6);

    curReq = "R6";
    wr(2'd0, 32'h00000005);
    setAddr(2'd1); idle(2);

    curReq = "R8";
    cellCode[0] = 8'h12; idle(2);
    oscOn = 1'b0; idle(2);
    cellCode[0] = 8'h34; cellCode[1] = 8'hC3; idle(3);

    curReq = "R9";
    wr(2'd1, 32'h0000FFFF);
    idle(1);
    wr(2'd0, 32'h00000305);
    oscOn = 1'b1; idle(7);
    wr(2'd1, 32'h00000000);
    idle(2);

    curReq = "R5";
    wr(2'd0, 32'h00000004);
    cellCode[1] = 8'hE1; idle(3);

    curReq = "R10";
    wr(2'd0, 32'h00000001);
    cellCode[0] = 8'h4B; cellCode[1] = 8'hB4;
    idle(8);
    setAddr(2'd1); idle(2);
    oscOn = 1'b0;
    setAddr(2'd0); idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule